// File: doc/BRIEF.md
# Queue Priority Configuration Validator

This block checks the scheduling set-up of one output port, one queue at a time. Software, or a configuration engine, streams one 4-bit priority code per queue. The first beat is marked with a start strobe and carries the port's first absolute queue number. The final beat is marked with a last strobe. For every queue the block emits a descriptor. Each descriptor carries the queue's position within the port, a tail flag, a static-queue flag, a static-tail flag and an 8-bit round-enable mask.

Codes 0 to 8 are weights. Each weight becomes an 8-bit mask whose set bits are spread evenly over the eight rounds. Code 9 selects strict (static) priority. Static queues must form one unbroken run that begins at the port's first queue.

After the final descriptor has been taken, the block pulses a status for one cycle. The status reports success, a queue range that runs past the end of the queue space, or an illegal priority set-up. Only the first error seen in a frame is kept.

Top module: `qprio_cfg_check`

## Requirements
- R1: Weight codes map to masks as follows: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF.
- R2: Code 9 sets the descriptor's static flag and gives mask 0xFF. All other codes clear the static flag.
- R3: A code of 10 or more gives mask 0xFF, is not static, and makes the frame status 2 (illegal priority).
- R4: A static code on a queue other than queue 0, when the queue before it is not static, makes the status 2. Static queues must therefore start at queue 0.
- R5: A static code that follows a non-static queue after a static run has ended makes the status 2. The static run must be contiguous.
- R6: The tail flag is 1 only on the descriptor of the frame's last queue.
- R7: The static-tail flag is 1 only on the last queue of the static run. If every queue is static, that is the frame's last queue.
- R8: For queue positions 16 and above, the code of queue (position mod 16) is used, and the code on the input for that beat is ignored.
- R9: If the first queue number plus a queue's position reaches 32 (the default queue count), the status is 1 (range).
- R10: Only the first error of a frame is kept. When one queue has both faults, range (1) outranks priority (2). Status 0 means no error. The status code is 2 bits.
- R11: Exactly one descriptor is produced per queue, in order, with position 0,1,2,…. A descriptor with out_valid high and out_ready low stays unchanged.
- R12: status_valid is high for exactly one cycle, in the cycle after the tail descriptor is accepted. Input is not accepted between a frame's last beat and that pulse. After reset, no descriptor or status is pending and input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Code beat valid |
| in_ready | output | 1 | Block can take a code beat |
| in_first | input | 1 | Beat is the port's first queue |
| in_last | input | 1 | Beat is the port's last queue |
| in_base | input | 5 | First absolute queue number, sampled with in_first |
| in_code | input | 4 | Priority code of this queue |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_index | output | 6 | Queue position within the port |
| out_tail | output | 1 | Last queue of the port |
| out_static | output | 1 | Queue uses strict priority |
| out_stail | output | 1 | Last queue of the static run |
| out_mask | output | 8 | Round-enable mask |
| status_valid | output | 1 | One-cycle frame status strobe |
| status_code | output | 2 | 0 ok, 1 range, 2 priority |

## Verification
The checker watches several properties on every cycle. A stalled descriptor must hold still. The static-tail flag may appear only on a static queue. A static tail queue must carry the static-tail flag, and a static queue must carry the full mask. The status strobe must be a single-cycle pulse that follows acceptance of a tail descriptor, and the status code must never take the unused value. Only the bench's frames can show the rest. These include the weight-to-mask values, where a static run ends, the modulo-16 reuse of codes, the range limit, and which error wins when several occur. The bench runs these frames against a reference model, with and without consumer stalls.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
   localparam int MASK_W      = 8;
   localparam int STATIC_CODE = 9;
   localparam int TOP_WEIGHT  = 8;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_RANGE = 2'd1,
      ST_PRIO  = 2'd2
   } qpc_status_e;
endpackage

// File: rtl/qpc_mask_enc.sv
module qpc_mask_enc
   import qpc_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [MASK_W-1:0] mask,
   output logic              is_static,
   output logic              is_bad
);
   always_comb begin
      is_static = (code == CODE_W'(STATIC_CODE));
      is_bad    = (code > CODE_W'(STATIC_CODE));
      unique case (code)
         CODE_W'(0): mask = 8'h00;
         CODE_W'(1): mask = 8'h01;
         CODE_W'(2): mask = 8'h11;
         CODE_W'(3): mask = 8'h49;
         CODE_W'(4): mask = 8'h55;
         CODE_W'(5): mask = 8'h57;
         CODE_W'(6): mask = 8'h77;
         CODE_W'(7): mask = 8'h7F;
         default:    mask = 8'hFF;
      endcase
   end
endmodule

// File: rtl/qpc_code_table.sv
module qpc_code_table #(
   parameter int DEPTH  = 16,
   parameter int CODE_W = 4,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [CODE_W-1:0] in_code,
   output logic [CODE_W-1:0] eff_code
);
   localparam int SLOT_W = $clog2(DEPTH);

   logic [CODE_W-1:0] mem [DEPTH];
   logic [SLOT_W-1:0] slot;
   logic              direct;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign slot = idx[SLOT_W-1:0];
      end else begin : g_modulo
         assign slot = SLOT_W'(idx % IDX_W'(DEPTH));
      end
   endgenerate

   assign direct   = (idx < IDX_W'(DEPTH));
   assign eff_code = direct ? in_code : mem[slot];

   always_ff @(posedge clk) begin
      if (wr_en && direct) mem[slot] <= in_code;
   end
endmodule

// File: rtl/qprio_cfg_check.sv
module qprio_cfg_check
   import qpc_pkg::*;
#(
   parameter int MAX_QUEUES  = 32,
   parameter int TABLE_DEPTH = 16,
   parameter int CODE_W      = 4,
   localparam int QID_W      = $clog2(MAX_QUEUES),
   localparam int IDX_W      = QID_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_first,
   input  logic              in_last,
   input  logic [QID_W-1:0]  in_base,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [IDX_W-1:0]  out_index,
   output logic              out_tail,
   output logic              out_static,
   output logic              out_stail,
   output logic [MASK_W-1:0] out_mask,
   output logic              status_valid,
   output logic [1:0]        status_code
);
   localparam int SUM_W = IDX_W + 1;

   generate
      if (MAX_QUEUES < 2) begin : g_bad_q
         $error("MAX_QUEUES must be at least 2");
      end
      if (TABLE_DEPTH < 2 || TABLE_DEPTH > MAX_QUEUES) begin : g_bad_t
         $error("TABLE_DEPTH must lie in 2..MAX_QUEUES");
      end
      if (CODE_W < 4) begin : g_bad_c
         $error("CODE_W must hold the static code");
      end
   endgenerate

   logic              acc, o_free, flush, out_done;
   logic [IDX_W-1:0]  idx_q, cur_idx;
   logic [QID_W-1:0]  base_q, cur_base;
   logic [CODE_W-1:0] eff_code;
   logic [MASK_W-1:0] cur_mask;
   logic              cur_static, cur_bad, prev_static_q;
   logic [SUM_W-1:0]  abs_q;
   logic              beat_range, beat_run;
   qpc_status_e       beat_err, err_q;
   logic              drain_q, stat_v_q;

   logic              p_valid, p_static, p_last;
   logic [IDX_W-1:0]  p_idx;
   logic [MASK_W-1:0] p_mask;

   logic              o_valid, o_tail, o_static, o_stail;
   logic [IDX_W-1:0]  o_idx;
   logic [MASK_W-1:0] o_mask;

   assign cur_idx  = in_first ? '0 : idx_q;
   assign cur_base = in_first ? in_base : base_q;

   qpc_code_table #(.DEPTH(TABLE_DEPTH), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_table (
      .clk      (clk),
      .wr_en    (acc),
      .idx      (cur_idx),
      .in_code  (in_code),
      .eff_code (eff_code)
   );

   qpc_mask_enc #(.CODE_W(CODE_W)) u_enc (
      .code      (eff_code),
      .mask      (cur_mask),
      .is_static (cur_static),
      .is_bad    (cur_bad)
   );

   assign o_free   = !o_valid || out_ready;
   assign in_ready = !drain_q && (!p_valid || o_free);
   assign acc      = in_valid && in_ready;
   assign flush    = drain_q && p_valid && o_free;
   assign out_done = o_valid && out_ready && o_tail;

   assign abs_q      = SUM_W'(cur_base) + SUM_W'(cur_idx);
   assign beat_range = (abs_q >= SUM_W'(MAX_QUEUES));
   assign beat_run   = cur_static && !in_first && !prev_static_q;

   always_comb begin
      if (beat_range)               beat_err = ST_RANGE;
      else if (cur_bad || beat_run) beat_err = ST_PRIO;
      else                          beat_err = ST_OK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q         <= '0;
         base_q        <= '0;
         prev_static_q <= 1'b0;
         err_q         <= ST_OK;
         drain_q       <= 1'b0;
         stat_v_q      <= 1'b0;
         p_valid       <= 1'b0;
         p_static      <= 1'b0;
         p_last        <= 1'b0;
         p_idx         <= '0;
         p_mask        <= '0;
         o_valid       <= 1'b0;
         o_tail        <= 1'b0;
         o_static      <= 1'b0;
         o_stail       <= 1'b0;
         o_idx         <= '0;
         o_mask        <= '0;
      end else begin
         stat_v_q <= out_done;
         if (out_done) drain_q <= 1'b0;

         if ((acc && p_valid) || flush) begin
            o_valid  <= 1'b1;
            o_idx    <= p_idx;
            o_tail   <= p_last;
            o_static <= p_static;
            o_stail  <= p_static && (p_last || !(acc && cur_static));
            o_mask   <= p_mask;
         end else if (out_ready) begin
            o_valid  <= 1'b0;
         end

         if (acc) begin
            idx_q         <= (cur_idx == '1) ? cur_idx : cur_idx + 1'b1;
            base_q        <= cur_base;
            prev_static_q <= cur_static;
            if (in_first || err_q == ST_OK) err_q <= beat_err;
            p_valid  <= 1'b1;
            p_idx    <= cur_idx;
            p_static <= cur_static;
            p_mask   <= cur_mask;
            p_last   <= in_last;
            if (in_last) drain_q <= 1'b1;
         end else if (flush) begin
            p_valid <= 1'b0;
         end
      end
   end

   assign out_valid    = o_valid;
   assign out_index    = o_idx;
   assign out_tail     = o_tail;
   assign out_static   = o_static;
   assign out_stail    = o_stail;
   assign out_mask     = o_mask;
   assign status_valid = stat_v_q;
   assign status_code  = err_q;
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             out_ready,
   input logic [IDX_W-1:0] out_index,
   input logic             out_tail,
   input logic             out_static,
   input logic             out_stail,
   input logic [7:0]       out_mask,
   input logic             status_valid,
   input logic [1:0]       status_code
);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_index) && $stable(out_mask)
                                  && $stable(out_tail) && $stable(out_stail) && $stable(out_static));

   p_stail_static_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_stail |-> out_static);

   p_tail_closes_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_tail && out_static |-> out_stail);

   p_static_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_static |-> out_mask == 8'hFF);

   p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |=> !status_valid);

   p_status_after_tail_r12: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> $past(out_valid && out_ready && out_tail));

   p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> status_code != 2'd3);
endmodule

bind qprio_cfg_check qpc_checker #(.IDX_W(IDX_W)) u_qpc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_index    (out_index),
   .out_tail     (out_tail),
   .out_static   (out_static),
   .out_stail    (out_stail),
   .out_mask     (out_mask),
   .status_valid (status_valid),
   .status_code  (status_code)
);

// File: tb/qprio_cfg_check_bench.sv
module qprio_cfg_check_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 32;

   // {code[14:11], mask[10:3], static[2], status[1:0]}
   localparam logic [14:0] VEC [12] = '{
      {4'd0,  8'h00, 1'b0, 2'd0}, {4'd1,  8'h01, 1'b0, 2'd0},
      {4'd2,  8'h11, 1'b0, 2'd0}, {4'd3,  8'h49, 1'b0, 2'd0},
      {4'd4,  8'h55, 1'b0, 2'd0}, {4'd5,  8'h57, 1'b0, 2'd0},
      {4'd6,  8'h77, 1'b0, 2'd0}, {4'd7,  8'h7F, 1'b0, 2'd0},
      {4'd8,  8'hFF, 1'b0, 2'd0}, {4'd9,  8'hFF, 1'b1, 2'd0},
      {4'd10, 8'hFF, 1'b0, 2'd2}, {4'd15, 8'hFF, 1'b0, 2'd2}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [4:0] in_base = '0;
   logic [3:0] in_code = '0;
   logic       in_ready, out_valid, out_tail, out_static, out_stail, status_valid;
   logic       out_ready = 1'b1;
   logic [5:0] out_index;
   logic [7:0] out_mask;
   logic [1:0] status_code;

   qprio_cfg_check u_qprio_cfg_check (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_first(in_first), .in_last(in_last), .in_base(in_base), .in_code(in_code),
      .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
      .out_tail(out_tail), .out_static(out_static), .out_stail(out_stail),
      .out_mask(out_mask), .status_valid(status_valid), .status_code(status_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0, bad = 0;
   int stall_mode = 0;
   logic [3:0] rcnt = '0;
   logic [3:0] codes [64];
   int   g_n = 0, g_idx [64], stat_cnt = 0, stat_got = 0;
   logic [7:0] g_mask [64];
   bit   g_tail [64], g_stat [64], g_stail [64];
   bit   pulse_expect = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      rcnt <= rcnt + 1'b1;
      out_ready <= (stall_mode == 0) ? 1'b1 : (stall_mode == 1) ? (rcnt[1:0] != 2'd0) : rcnt[0];
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (pulse_expect) chk(status_valid == 1'b1, "R12 status one cycle after tail", status_valid, 1);
         else if (status_valid) chk(1'b0, "R12 stray status pulse", 1, 0);
         if (status_valid) begin
            stat_cnt++;
            stat_got = status_code;
         end
         pulse_expect = out_valid && out_ready && out_tail;
         if (out_valid && out_ready && g_n < 64) begin
            g_idx[g_n] = out_index;  g_mask[g_n] = out_mask;
            g_tail[g_n] = out_tail;  g_stat[g_n] = out_static;
            g_stail[g_n] = out_stail;
            g_n++;
         end
      end
   end

   function automatic logic [7:0] wmask(input int c);
      case (c)
         0: return 8'h00; 1: return 8'h01; 2: return 8'h11; 3: return 8'h49;
         4: return 8'h55; 5: return 8'h57; 6: return 8'h77; 7: return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic send_frame(input int base, input int n);
      g_n = 0;
      stat_cnt = 0;
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1; in_first = (i == 0); in_last = (i == n - 1);
         in_base = 5'(base); in_code = codes[i];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      for (int k = 0; k < 400 && stat_cnt == 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_frame(input int base, input int n, input string mtag, input string stag);
      int c [64];
      bit s [64];
      int st;
      st = 0;
      for (int i = 0; i < n; i++) begin
         c[i] = codes[i % 16];
         s[i] = (c[i] == 9);
      end
      for (int i = 0; i < n; i++) begin
         if (st == 0) begin
            if (base + i >= NQ) st = 1;
            else if (c[i] > 9) st = 2;
            else if (s[i] && i > 0 && !s[i-1]) st = 2;
         end
      end
      chk(g_n == n, "R11 descriptor count", g_n, n);
      chk(stat_cnt == 1, "R12 one status per frame", stat_cnt, 1);
      chk(stat_got == st, stag, stat_got, st);
      for (int i = 0; i < n && i < g_n; i++) begin
         chk(g_idx[i] == i, "R11 index order", g_idx[i], i);
         chk(g_mask[i] == ((c[i] >= 9) ? 8'hFF : wmask(c[i])), mtag, g_mask[i],
             (c[i] >= 9) ? 255 : int'(wmask(c[i])));
         chk(g_stat[i] == s[i], "R2 static flag", g_stat[i], s[i]);
         chk(g_tail[i] == (i == n - 1), "R6 tail flag", g_tail[i], (i == n - 1));
         chk(g_stail[i] == (s[i] && (i == n - 1 || !s[i+1])), "R7 static tail",
             g_stail[i], (s[i] && (i == n - 1 || !s[i+1])));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R11 reset no descriptor", out_valid, 0);
      chk(status_valid == 1'b0, "R12 reset no status", status_valid, 0);
      chk(in_ready == 1'b1, "R12 reset input ready", in_ready, 1);

      // table walk: one-queue frames, R1 R2 R3
      for (int k = 0; k < 12; k++) begin
         codes[0] = VEC[k][14:11];
         send_frame(0, 1);
         chk(g_mask[0] == VEC[k][10:3], "R1 table mask", g_mask[0], VEC[k][10:3]);
         chk(g_stat[0] == VEC[k][2], "R2 table static", g_stat[0], VEC[k][2]);
         chk(stat_got == VEC[k][1:0], "R3 table status", stat_got, VEC[k][1:0]);
      end

      // all static, stalled consumer (R7)
      stall_mode = 1;
      for (int i = 0; i < 5; i++) codes[i] = 4'd9;
      send_frame(3, 5);
      check_frame(3, 5, "R2 mask all static", "R7 status all static");

      // static run then weights (R7)
      stall_mode = 2;
      codes[0] = 9; codes[1] = 9; codes[2] = 3; codes[3] = 4;
      send_frame(0, 4);
      check_frame(0, 4, "R1 mask mixed", "R7 status mixed");

      // static not at queue 0 (R4)
      stall_mode = 0;
      codes[0] = 5; codes[1] = 9;
      send_frame(0, 2);
      check_frame(0, 2, "R1 mask late static", "R4 status late static");

      // broken static run (R5)
      codes[0] = 9; codes[1] = 5; codes[2] = 9;
      send_frame(0, 3);
      check_frame(0, 3, "R1 mask broken run", "R5 status broken run");

      // more than 16 queues: inputs 16..19 ignored (R8)
      stall_mode = 1;
      for (int i = 0; i < 16; i++) codes[i] = 4'(i % 9);
      for (int i = 16; i < 20; i++) codes[i] = 4'd12;
      send_frame(0, 20);
      check_frame(0, 20, "R8 mask wrapped code", "R8 status wrapped code");

      // range overflow (R9)
      stall_mode = 0;
      for (int i = 0; i < 4; i++) codes[i] = 4'd2;
      send_frame(30, 4);
      check_frame(30, 4, "R1 mask range", "R9 status range");

      // first error held: priority on q0 then range on q1 (R10)
      codes[0] = 12; codes[1] = 1;
      send_frame(31, 2);
      check_frame(31, 2, "R3 mask first error", "R10 status first error");

      // range and priority on the same queue (R10)
      codes[0] = 1; codes[1] = 12;
      send_frame(31, 2);
      check_frame(31, 2, "R3 mask same queue", "R10 status range outranks");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule